// File: doc/BRIEF.md
# Hexadecimal Floating-Point Divider

This block divides one 32-bit hexadecimal floating-point number by another. A word holds a sign bit, a seven-bit exponent in excess-64 code and a six-digit hexadecimal fraction. The value of a word is (-1)^s * 0.f * 16^(e-64). Both operands are first normalized, one hex digit per clock. The block then checks the exponent and pre-aligns the dividend so that every quotient digit lies in the range 0 to 15. It then builds the quotient one hex digit at a time. Each digit is formed by repeated trial subtraction, with one trial per clock.

A host pulses `start` with both operands and the rounding select while the block is idle. The block raises `busy` and works through its states. It ends with a one-cycle `done` pulse, together with the packed quotient and a condition code. Division by a zero fraction is reported by the condition code alone: `result_write` stays low and the held quotient is left untouched.

The control states are as follows:
- `ST_IDLE` waits for `start`.
- `ST_NORM` shifts the unnormalized operands until both are normalized.
- `ST_SETUP` sorts out the special cases. It goes to `ST_FINISH` for a zero operand or an exponent out of range, and otherwise pre-aligns the dividend and goes to `ST_DIVIDE`.
- `ST_DIVIDE` stays put while a subtraction fits. When the sixth digit is complete it goes to `ST_ROUND`.
- `ST_ROUND` rounds and packs the result, then goes to `ST_FINISH`.
- `ST_FINISH` pulses `done` and returns to `ST_IDLE`.

Top module: `hfd_divider`

## Requirements
- R1: A `start` pulse seen in idle captures the operands. `busy` is high from the next cycle and stays high until the cycle in which `done` pulses for exactly one cycle. A `start` pulse while busy is ignored.
- R2: Word layout: bit 31 is the sign, bits 30:24 the excess-64 exponent and bits 23:0 the fraction. An operand whose top hex digit is zero is normalized before use by 4-bit left shifts, each lowering its exponent by one.
- R3: A zero divisor fraction gives `cond_code` = 4'b1100, with bit 3 = C, bit 2 = V, bit 1 = G and bit 0 = L. `result_write` stays low and `quotient` keeps its previous value.
- R4: A zero dividend fraction with a nonzero divisor gives an all-zero result with `cond_code` 0 and `result_write` high.
- R5: The sign of the result is the XOR of the operand signs. The exponent is e1 - e2 + 64, plus one when the normalized dividend fraction is not below the normalized divisor fraction. The fraction is the normalized six-digit quotient.
- R6: An exponent e1 - e2 + 64 below 0 gives an all-zero result with `cond_code` 4'b0100.
- R7: An exponent above 127 gives the sign followed by all ones, with `cond_code` 4'b0110 when positive and 4'b0101 when negative. The exponent is checked both before and after the pre-alignment increment and after a rounding carry.
- R8: With `round_en` high, one unit is added to the last fraction digit when the final remainder is at least half the divisor. The remainder is compared, shifted left one digit, against eight times the divisor.
- R9: With `round_en` low, the fraction is truncated.
- R10: A result that is neither an exception nor zero sets `cond_code` to 4'b0001 when negative and 4'b0010 when positive.
- R11: Each quotient digit takes at most 16 cycles in `ST_DIVIDE`. A whole division completes within 110 cycles of `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a division (taken in idle only) |
| round_en | input | 1 | Round the last digit when high, truncate when low |
| dividend | input | 32 | Dividend word |
| divisor | input | 32 | Divisor word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result_write | output | 1 | High with `done` when `quotient` carries a new result |
| quotient | output | 32 | Packed result, held between operations |
| cond_code | output | 4 | C, V, G, L flags (bits 3 to 0) |

## Verification
The bound checker watches the handshake on every cycle: `busy` holds until `done`, and `done` is a single-cycle pulse. On every completion it also checks that a suppressed write carries the divide-by-zero code, that the L and G flags agree with the sign and zero-ness of the packed word, and that a normal result has a nonzero leading digit. In addition, a counter limits every run of trial subtractions to fifteen.

Only the bench's scenarios can show that the quotient digits, the rounding decision and the exception boundaries are numerically right. It sweeps normalized and unnormalized fractions across several exponent pairs, signs and both rounding modes, and compares each result with a quotient computed by integer division.

// File: rtl/hfd_pkg.sv
package hfd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NORM,
        ST_SETUP,
        ST_DIVIDE,
        ST_ROUND,
        ST_FINISH
    } hfd_state_e;

    // condition code bit positions
    localparam int CC_C = 3;
    localparam int CC_V = 2;
    localparam int CC_G = 1;
    localparam int CC_L = 0;
endpackage

// File: rtl/hfd_norm_step.sv
// One hex-digit normalization step for an unpacked operand.
module hfd_norm_step #(
    parameter int FRAC_W = 24,
    parameter int XW     = 11
) (
    input  logic [FRAC_W-1:0]        frac_i,
    input  logic signed [XW-1:0]     exp_i,
    output logic [FRAC_W-1:0]        frac_o,
    output logic signed [XW-1:0]     exp_o,
    output logic                     norm_o
);
    always_comb begin
        norm_o = (frac_i == '0) || (frac_i[FRAC_W-1 -: 4] != 4'h0);
        if (norm_o) begin
            frac_o = frac_i;
            exp_o  = exp_i;
        end else begin
            frac_o = frac_i << 4;
            exp_o  = exp_i - XW'(1);
        end
    end
endmodule

// File: rtl/hfd_trial_sub.sv
// Trial subtraction of the divisor from the partial remainder.
module hfd_trial_sub #(
    parameter int REM_W = 28
) (
    input  logic [REM_W-1:0] rem_i,
    input  logic [REM_W-1:0] dvs_i,
    output logic             fits_o,
    output logic [REM_W-1:0] diff_o
);
    always_comb begin
        fits_o = (rem_i >= dvs_i);
        diff_o = rem_i - dvs_i;
    end
endmodule

// File: rtl/hfd_packer.sv
// Final rounding, carry renormalization, range check and packing.
module hfd_packer #(
    parameter int FRAC_W = 24,
    parameter int EXP_W  = 7,
    parameter int REM_W  = FRAC_W + 4,
    parameter int XW     = EXP_W + 4
) (
    input  logic                      sign_i,
    input  logic signed [XW-1:0]      exp_i,
    input  logic [FRAC_W-1:0]         quo_i,
    input  logic [REM_W-1:0]          rem_i,
    input  logic [REM_W-1:0]          dvs_i,
    input  logic                      round_i,
    output logic [EXP_W+FRAC_W:0]     word_o,
    output logic [3:0]                cc_o
);
    import hfd_pkg::*;

    localparam int EMAX = (1 << EXP_W) - 1;

    logic              bump;
    logic [FRAC_W:0]   sum;
    logic [FRAC_W-1:0] frac_f;
    logic signed [XW-1:0] exp_f;

    always_comb begin
        bump   = round_i && (rem_i >= (dvs_i << 3));
        sum    = {1'b0, quo_i} + (FRAC_W+1)'(bump);
        if (sum[FRAC_W]) begin
            frac_f = FRAC_W'(sum >> 4);
            exp_f  = exp_i + XW'(1);
        end else begin
            frac_f = sum[FRAC_W-1:0];
            exp_f  = exp_i;
        end
        cc_o = '0;
        if (exp_f > $signed(XW'(EMAX))) begin
            word_o     = {sign_i, {(EXP_W+FRAC_W){1'b1}}};
            cc_o[CC_V] = 1'b1;
            cc_o[CC_L] = sign_i;
            cc_o[CC_G] = !sign_i;
        end else if (exp_f < $signed(XW'(0)) || frac_f == '0) begin
            word_o     = '0;
            cc_o[CC_V] = (exp_f < $signed(XW'(0)));
        end else begin
            word_o     = {sign_i, exp_f[EXP_W-1:0], frac_f};
            cc_o[CC_L] = sign_i;
            cc_o[CC_G] = !sign_i;
        end
    end
endmodule

// File: rtl/hfd_divider.sv
// Hexadecimal floating-point divider, one trial subtraction per clock.
module hfd_divider #(
    parameter int FRAC_W = 24,
    parameter int EXP_W  = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   round_en,
    input  logic [EXP_W+FRAC_W:0]  dividend,
    input  logic [EXP_W+FRAC_W:0]  divisor,
    output logic                   busy,
    output logic                   done,
    output logic                   result_write,
    output logic [EXP_W+FRAC_W:0]  quotient,
    output logic [3:0]             cond_code
);
    import hfd_pkg::*;

    localparam int W      = EXP_W + FRAC_W + 1;
    localparam int DIGITS = FRAC_W / 4;
    localparam int REM_W  = FRAC_W + 4;
    localparam int XW     = EXP_W + 4;
    localparam int BIAS   = 1 << (EXP_W - 1);
    localparam int EMAX   = (1 << EXP_W) - 1;
    localparam int CNT_W  = $clog2(DIGITS);

    hfd_state_e state, nxt;

    // unpacked operands: index 0 dividend, 1 divisor
    logic [FRAC_W-1:0]    opf_q [2];
    logic signed [XW-1:0] ope_q [2];
    logic [1:0]           ops_q;
    logic [FRAC_W-1:0]    opf_n [2];
    logic signed [XW-1:0] ope_n [2];
    logic [1:0]           norm_ok;

    logic                 rnd_q;
    logic [REM_W-1:0]     rem_q;
    logic [REM_W-1:0]     dvs_q;
    logic [FRAC_W-1:0]    quo_q;
    logic signed [XW-1:0] qexp_q;
    logic                 qsign_q;
    logic [CNT_W-1:0]     digit_q;
    logic [W-1:0]         res_q;
    logic [3:0]           cc_q;
    logic                 wr_q;

    logic                 sub_fits;
    logic [REM_W-1:0]     sub_diff;
    logic [W-1:0]         pack_word;
    logic [3:0]           pack_cc;

    logic signed [XW-1:0] exp_raw;
    logic signed [XW-1:0] exp_adj;
    logic                 a_lt_b;
    logic                 setup_go;
    logic                 last_digit;

    for (genvar g = 0; g < 2; g++) begin : g_norm
        hfd_norm_step #(.FRAC_W(FRAC_W), .XW(XW)) u_norm (
            .frac_i (opf_q[g]),
            .exp_i  (ope_q[g]),
            .frac_o (opf_n[g]),
            .exp_o  (ope_n[g]),
            .norm_o (norm_ok[g])
        );
    end

    hfd_trial_sub #(.REM_W(REM_W)) u_sub (
        .rem_i  (rem_q),
        .dvs_i  (dvs_q),
        .fits_o (sub_fits),
        .diff_o (sub_diff)
    );

    hfd_packer #(.FRAC_W(FRAC_W), .EXP_W(EXP_W), .REM_W(REM_W), .XW(XW)) u_pack (
        .sign_i  (qsign_q),
        .exp_i   (qexp_q),
        .quo_i   (quo_q),
        .rem_i   (rem_q),
        .dvs_i   (dvs_q),
        .round_i (rnd_q),
        .word_o  (pack_word),
        .cc_o    (pack_cc)
    );

    // setup classification
    always_comb begin
        exp_raw    = ope_q[0] - ope_q[1] + $signed(XW'(BIAS));
        a_lt_b     = (opf_q[0] < opf_q[1]);
        exp_adj    = a_lt_b ? exp_raw : exp_raw + XW'(1);
        setup_go   = (opf_q[1] != '0) && (opf_q[0] != '0) &&
                     (exp_raw >= $signed(XW'(0))) &&
                     (exp_adj <= $signed(XW'(EMAX)));
        last_digit = (digit_q == CNT_W'(DIGITS - 1));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_NORM;
            ST_NORM:   if (&norm_ok) nxt = ST_SETUP;
            ST_SETUP:  nxt = setup_go ? ST_DIVIDE : ST_FINISH;
            ST_DIVIDE: if (!sub_fits && last_digit) nxt = ST_ROUND;
            ST_ROUND:  nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                opf_q[i] <= '0;
                ope_q[i] <= '0;
            end
            ops_q   <= '0;
            rnd_q   <= 1'b0;
            rem_q   <= '0;
            dvs_q   <= '0;
            quo_q   <= '0;
            qexp_q  <= '0;
            qsign_q <= 1'b0;
            digit_q <= '0;
            res_q   <= '0;
            cc_q    <= '0;
            wr_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        opf_q[0] <= dividend[FRAC_W-1:0];
                        opf_q[1] <= divisor[FRAC_W-1:0];
                        ope_q[0] <= $signed({{(XW-EXP_W){1'b0}}, dividend[FRAC_W +: EXP_W]});
                        ope_q[1] <= $signed({{(XW-EXP_W){1'b0}}, divisor[FRAC_W +: EXP_W]});
                        ops_q    <= {divisor[W-1], dividend[W-1]};
                        rnd_q    <= round_en;
                    end
                end
                ST_NORM: begin
                    for (int i = 0; i < 2; i++) begin
                        opf_q[i] <= opf_n[i];
                        ope_q[i] <= ope_n[i];
                    end
                end
                ST_SETUP: begin
                    qsign_q <= ops_q[0] ^ ops_q[1];
                    if (opf_q[1] == '0) begin
                        cc_q <= 4'b1100;
                        wr_q <= 1'b0;
                    end else if (opf_q[0] == '0) begin
                        res_q <= '0;
                        cc_q  <= 4'b0000;
                        wr_q  <= 1'b1;
                    end else if (exp_raw < $signed(XW'(0))) begin
                        res_q <= '0;
                        cc_q  <= 4'b0100;
                        wr_q  <= 1'b1;
                    end else if (exp_adj > $signed(XW'(EMAX))) begin
                        res_q <= {ops_q[0] ^ ops_q[1], {(W-1){1'b1}}};
                        cc_q  <= (ops_q[0] ^ ops_q[1]) ? 4'b0101 : 4'b0110;
                        wr_q  <= 1'b1;
                    end else begin
                        rem_q   <= a_lt_b ? {opf_q[0], 4'h0} : {4'h0, opf_q[0]};
                        dvs_q   <= {4'h0, opf_q[1]};
                        qexp_q  <= exp_adj;
                        quo_q   <= '0;
                        digit_q <= '0;
                    end
                end
                ST_DIVIDE: begin
                    if (sub_fits) begin
                        rem_q <= sub_diff;
                        quo_q <= quo_q + FRAC_W'(1);
                    end else begin
                        rem_q <= rem_q << 4;
                        if (!last_digit) begin
                            digit_q <= digit_q + CNT_W'(1);
                            quo_q   <= quo_q << 4;
                        end
                    end
                end
                ST_ROUND: begin
                    res_q <= pack_word;
                    cc_q  <= pack_cc;
                    wr_q  <= 1'b1;
                end
                ST_FINISH: begin
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy         = (state != ST_IDLE);
        done         = (state == ST_FINISH);
        result_write = done && wr_q;
        quotient     = res_q;
        cond_code    = cc_q;
    end
endmodule

// File: rtl/hfd_divider_checker.sv
module hfd_divider_checker #(
    parameter int FRAC_W = 24,
    parameter int EXP_W  = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  busy,
    input logic                  done,
    input logic                  result_write,
    input logic [EXP_W+FRAC_W:0] quotient,
    input logic [3:0]            cond_code,
    input hfd_pkg::hfd_state_e   state,
    input logic                  fits
);
    import hfd_pkg::*;

    localparam int W = EXP_W + FRAC_W + 1;

    logic [4:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            run_cnt <= '0;
        else if (state == ST_DIVIDE && fits)   run_cnt <= run_cnt + 5'd1;
        else                                   run_cnt <= '0;
    end

    // R1
    a_r1_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy);
    // R1
    a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R1
    a_r1_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    // R3
    a_r3_nowrite_div0: assert property (@(posedge clk) disable iff (!rst_n)
        done && !result_write |-> cond_code == 4'b1100);
    // R5
    a_r5_normalized: assert property (@(posedge clk) disable iff (!rst_n)
        done && result_write && !cond_code[CC_V] && (cond_code[1:0] != 2'b00)
        |-> quotient[FRAC_W-1 -: 4] != 4'h0);
    // R10
    a_r10_cc_sign: assert property (@(posedge clk) disable iff (!rst_n)
        done && result_write |-> (cond_code[CC_L] == quotient[W-1]) &&
        (cond_code[CC_G] == (!quotient[W-1] && quotient[W-2:0] != '0)));
    // R11
    a_r11_digit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIVIDE && fits) |-> run_cnt < 5'd15);
endmodule

bind hfd_divider hfd_divider_checker #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .result_write (result_write),
    .quotient     (quotient),
    .cond_code    (cond_code),
    .state        (state),
    .fits         (sub_fits)
);

// File: tb/hfd_divider_test.sv
module hfd_divider_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        round_en = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        busy, done, result_write;
    logic [31:0] quotient;
    logic [3:0]  cond_code;

    int total = 0;
    int bad = 0;
    int max_lat = 0;

    always #5 clk = ~clk;

    hfd_divider uut (
        .clk(clk), .rst_n(rst_n), .start(start), .round_en(round_en),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .result_write(result_write), .quotient(quotient), .cond_code(cond_code)
    );

    function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                  input logic rnd, output logic [31:0] q,
                                  output logic [3:0] cc, output logic wr,
                                  output string tag);
        longint fa, fb, num, quo, r;
        int ea, eb, e;
        logic s;
        fa = longint'(a[23:0]); fb = longint'(b[23:0]);
        ea = int'(a[30:24]);    eb = int'(b[30:24]);
        tag = ((fa != 0 && fa < 'h100000) || (fb != 0 && fb < 'h100000)) ? "R2 " : "";
        while (fa != 0 && fa < 'h100000) begin fa = fa * 16; ea--; end
        while (fb != 0 && fb < 'h100000) begin fb = fb * 16; eb--; end
        s = a[31] ^ b[31];
        q = '0; cc = 4'b0000; wr = 1'b1;
        if (fb == 0) begin wr = 1'b0; cc = 4'b1100; tag = {tag, "R3"}; return; end
        if (fa == 0) begin tag = {tag, "R4"}; return; end
        e = ea - eb + 64;
        if (e < 0) begin cc = 4'b0100; tag = {tag, "R6"}; return; end
        if (fa < fb) num = fa <<< 24;
        else begin e++; num = fa <<< 20; end
        if (e > 127 || ea - eb + 64 > 127) begin
            q = {s, 31'h7FFFFFFF}; cc = s ? 4'b0101 : 4'b0110; tag = {tag, "R7"}; return;
        end
        quo = num / fb; r = num % fb;
        if (rnd) begin
            tag = {tag, "R8 "};
            if (2 * r >= fb) quo++;
        end else tag = {tag, "R9 "};
        if (quo >= 'h1000000) begin quo = quo / 16; e++; end
        if (e > 127) begin
            q = {s, 31'h7FFFFFFF}; cc = s ? 4'b0101 : 4'b0110; tag = {tag, "R7"}; return;
        end
        q = {s, 7'(e), 24'(quo)};
        cc = s ? 4'b0001 : 4'b0010;
        tag = {tag, "R5 R10"};
    endfunction

    task automatic check(input bit ok, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          input logic rnd, input bit poke);
        logic [31:0] eq;
        logic [3:0]  ecc;
        logic        ewr;
        string       tag;
        logic [31:0] prev_q;
        int          lat;
        model(a, b, rnd, eq, ecc, ewr, tag);
        prev_q = quotient;
        @(negedge clk);
        dividend = a; divisor = b; round_en = rnd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        // R1: busy rises the cycle after start
        check(busy === 1'b1, $sformatf("R1 busy after start got=%b exp=1", busy));
        while (!done && lat < 400) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 3) begin
                dividend = 32'hC1_777777; divisor = 32'h40_300000; start = 1'b1;
            end else if (poke && lat == 4) begin
                start = 1'b0;
            end
        end
        if (lat > max_lat) max_lat = lat;
        if (!done) begin
            check(1'b0, $sformatf("R11 no done got lat=%0d exp<=110", lat));
        end else if (!ewr) begin
            check(result_write == 1'b0 && cond_code == ecc && quotient == prev_q,
                  $sformatf("%s a=%h b=%h got q=%h cc=%b wr=%b exp q=%h cc=%b wr=0",
                            tag, a, b, quotient, cond_code, result_write, prev_q, ecc));
        end else begin
            check(result_write == 1'b1 && cond_code == ecc && quotient == eq,
                  $sformatf("%s%s a=%h b=%h rnd=%b got q=%h cc=%b wr=%b exp q=%h cc=%b wr=1",
                            poke ? "R1 " : "", tag, a, b, rnd, quotient, cond_code,
                            result_write, eq, ecc));
        end
        @(negedge clk);
        check(done == 1'b0, $sformatf("R1 done pulse length got=%b exp=0", done));
    endtask

    initial begin
        logic [23:0] fr [6];
        logic [6:0]  ex1 [4];
        logic [6:0]  ex2 [4];
        fr[0] = 24'h100000; fr[1] = 24'h123456; fr[2] = 24'h800000;
        fr[3] = 24'hFFFFFF; fr[4] = 24'h0ABCDE; fr[5] = 24'h000F31;
        ex1[0] = 7'h41; ex2[0] = 7'h40;
        ex1[1] = 7'h40; ex2[1] = 7'h47;
        ex1[2] = 7'h10; ex2[2] = 7'h50;
        ex1[3] = 7'h70; ex2[3] = 7'h38;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 0 && done == 0 && result_write == 0 && quotient == 0 && cond_code == 0,
              $sformatf("R1 reset got busy=%b done=%b q=%h cc=%b exp all zero",
                        busy, done, quotient, cond_code));
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        run_op(32'h41_200000, 32'h41_100000, 1'b0, 1'b0);  // R5 simple 2/1
        run_op(32'h41_200000, 32'h00_000000, 1'b0, 1'b0);  // R3 zero divisor
        run_op(32'hC3_123456, 32'h80_000000, 1'b1, 1'b0);  // R3 negative zero divisor
        run_op(32'h00_000000, 32'h41_100000, 1'b0, 1'b0);  // R4 zero dividend
        run_op(32'h80_000000, 32'hC5_543210, 1'b1, 1'b0);  // R4 signed zero
        run_op(32'h00_100000, 32'h41_200000, 1'b0, 1'b0);  // R6 underflow
        run_op(32'h01_000001, 32'h40_100000, 1'b0, 1'b0);  // R2 R6 underflow after normalization
        run_op(32'h7F_800000, 32'h40_100000, 1'b0, 1'b0);  // R7 overflow after increment
        run_op(32'hFF_100000, 32'h20_200000, 1'b1, 1'b0);  // R7 negative overflow
        run_op(32'h7F_100000, 32'h40_200000, 1'b0, 1'b0);  // R5 exponent exactly 127
        run_op(32'h41_100000, 32'h41_300000, 1'b0, 1'b0);  // R9 1/3 truncated
        run_op(32'h41_100000, 32'h41_300000, 1'b1, 1'b0);  // R8 1/3 rounded
        run_op(32'h41_200000, 32'h41_300000, 1'b1, 1'b0);  // R8 2/3 rounded up
        run_op(32'h41_200000, 32'hC1_300000, 1'b0, 1'b0);  // R10 negative
        run_op(32'h44_FFFFFE, 32'h44_FFFFFF, 1'b1, 1'b0);  // R8 near one
        run_op(32'h42_654321, 32'h41_123457, 1'b1, 1'b1);  // R1 start while busy ignored

        // sweep over fractions, exponent pairs, signs and rounding
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
                for (int k = 0; k < 4; k++)
                    for (int m = 0; m < 2; m++)
                        run_op({i[0], ex1[k], fr[i]}, {j[1] ^ m[0], ex2[k], fr[j]},
                               m[0], 1'b0);

        // R11 latency bound
        check(max_lat <= 110, $sformatf("R11 latency got=%0d exp<=110", max_lat));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R11 got=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule